// File: doc/BRIEF.md
# Two-Level Linear-to-Physical Address Walker

The walker turns a 32-bit linear address into a physical address. It reads a two-level translation table held in memory. A request carries three things: the linear address, the current value of the page-directory base register, and the paging-enable bit, which is bit 31 of the processor control register. When paging is enabled, the walker makes two word reads, one after the other. The first read fetches the directory entry and the second fetches the table entry. It then returns the physical address together with the combined read/write and user attributes. When either entry is marked not present, it returns a fault and the level that failed instead.

When paging is disabled, the walker does not touch memory. It hands the linear address back unchanged as the physical address on the next cycle. Memory reads use a valid/ready request channel and a separate response strobe, so the walker works with memories of any latency. The walker serves one request at a time and has no translation cache.

Top module: `lin2phys_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_rd_valid` is 0 and `res_valid` is 0.
- R2: A request is accepted only while `req_ready` is 1. Once a request is accepted, `req_ready` stays 0 until the cycle after that request's result pulse.
- R3: If `req_paging` is 0 when a request is accepted, no memory read is issued. The result appears on the next cycle with `res_phys` equal to the linear address, `res_fault` 0, and `res_rw` and `res_user` both 1.
- R4: The first read goes to the directory entry. Its address is base register bits 31:12, then linear bits 31:22, then two zero bits.
- R5: The second read goes to the table entry. Its address is directory-entry bits 31:12, then linear bits 21:12, then two zero bits.
- R6: On a successful walk, `res_phys` is table-entry bits 31:12 followed by linear bits 11:0. Each table therefore maps 1024 frames that lie 0x1000 apart.
- R7: If bit 0 (present) of the directory entry is 0, the walker reports `res_fault`=1 with `res_fault_lvl`=0, and it issues no second read.
- R8: If bit 0 of the table entry is 0, the walker reports `res_fault`=1 with `res_fault_lvl`=1, after exactly two reads.
- R9: `res_rw` is the AND of bit 1 of both entries. `res_user` is the AND of bit 2 of both entries. An entry low value of 0x007 therefore gives present, writable and user.
- R10: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, `mem_rd_valid` stays 1 and `mem_rd_addr` stays unchanged on the following cycle.
- R11: `res_valid` is high for exactly one cycle per accepted request, and the result fields are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_lin | input | 32 | Linear address to translate |
| req_base | input | 32 | Page-directory base register value |
| req_paging | input | 1 | Paging-enable bit (control register bit 31) |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| res_valid | output | 1 | One-cycle result strobe |
| res_phys | output | 32 | Translated physical address |
| res_rw | output | 1 | Combined read/write attribute |
| res_user | output | 1 | Combined user attribute |
| res_fault | output | 1 | Walk stopped on a non-present entry |
| res_fault_lvl | output | 1 | Failing level: 0 directory, 1 table |

## Verification
Two things can coincide at the request edge. The result pulse of one translation can fall in the same cycle as the next request, which is already waiting on `req_valid`. The bench provokes this by keeping `req_valid` asserted back to back, so each new request sits on the port while the previous walk finishes. It then judges two things. First, every request must produce exactly one result, matched in order from the scoreboard queue, and carrying its own physical address, attributes and read count. Second, a held request must never be taken before its predecessor has reported. Memory stalls and response latency are varied, so that the directory and table phases see the request channel held and then released.

// File: rtl/walk_pkg.sv
package walk_pkg;
  parameter int ADDR_W  = 32;
  parameter int OFF_W   = 12;
  parameter int IDX_W   = 10;
  localparam int ENT_LG = OFF_W - IDX_W;        // log2 of entry bytes
  localparam int FRM_W  = ADDR_W - OFF_W;       // frame number width
  localparam int BIT_PRESENT = 0;
  localparam int BIT_RW      = 1;
  localparam int BIT_USER    = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_TBL_REQ,
    ST_TBL_WAIT,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/walk_ctl.sv
module walk_ctl
  import walk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_paging,
  input  logic mem_rd_ready,
  input  logic mem_rsp_valid,
  input  logic rsp_present,
  output logic req_ready,
  output logic mem_rd_valid,
  output logic res_valid,
  output logic tbl_phase,
  output logic accept,
  output logic dir_ok,
  output logic dir_flt,
  output logic tbl_end
);
  walk_st_e state_q, state_d;

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_DIR_REQ) || (state_q == ST_TBL_REQ);
  assign res_valid    = (state_q == ST_DONE);
  assign tbl_phase    = (state_q == ST_TBL_REQ);
  assign accept       = req_ready && req_valid;
  assign dir_ok       = (state_q == ST_DIR_WAIT) && mem_rsp_valid && rsp_present;
  assign dir_flt      = (state_q == ST_DIR_WAIT) && mem_rsp_valid && !rsp_present;
  assign tbl_end      = (state_q == ST_TBL_WAIT) && mem_rsp_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid) state_d = req_paging ? ST_DIR_REQ : ST_DONE;
      ST_DIR_REQ:  if (mem_rd_ready) state_d = ST_DIR_WAIT;
      ST_DIR_WAIT: if (mem_rsp_valid) state_d = rsp_present ? ST_TBL_REQ : ST_DONE;
      ST_TBL_REQ:  if (mem_rd_ready) state_d = ST_TBL_WAIT;
      ST_TBL_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid);
  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (!res_valid && req_ready));
  // R7
  dir_fault_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_flt) |=> (res_valid && !mem_rd_valid));
endmodule

// File: rtl/walk_dp.sv
module walk_dp
  import walk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_paging,
  input  logic [ADDR_W-1:0] req_lin,
  input  logic [ADDR_W-1:0] req_base,
  input  logic              dir_ok,
  input  logic              dir_flt,
  input  logic              tbl_end,
  input  logic              tbl_phase,
  input  logic [ADDR_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic [ADDR_W-1:0] res_phys,
  output logic              res_rw,
  output logic              res_user,
  output logic              res_fault,
  output logic              res_fault_lvl
);
  logic [ADDR_W-1:0] lin_q;
  logic [FRM_W-1:0]  base_q;
  logic [FRM_W-1:0]  pde_frm_q;
  logic              pde_rw_q, pde_user_q;

  logic [IDX_W-1:0]  dir_idx, tbl_idx;
  assign dir_idx = lin_q[ADDR_W-1 -: IDX_W];
  assign tbl_idx = lin_q[OFF_W +: IDX_W];

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q  <= '0;
      base_q <= '0;
    end else if (accept) begin
      lin_q  <= req_lin;
      base_q <= req_base[ADDR_W-1:OFF_W];
    end
  end

  // directory entry capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pde_frm_q  <= '0;
      pde_rw_q   <= 1'b0;
      pde_user_q <= 1'b0;
    end else if (dir_ok) begin
      pde_frm_q  <= rsp_data[ADDR_W-1:OFF_W];
      pde_rw_q   <= rsp_data[BIT_RW];
      pde_user_q <= rsp_data[BIT_USER];
    end
  end

  assign mem_rd_addr = tbl_phase ? {pde_frm_q, tbl_idx, {ENT_LG{1'b0}}}
                                 : {base_q,    dir_idx, {ENT_LG{1'b0}}};

  // result next-state
  logic [ADDR_W-1:0] phys_d;
  logic              rw_d, user_d, flt_d, lvl_d, res_en;

  always_comb begin
    res_en = 1'b0;
    phys_d = res_phys;
    rw_d   = res_rw;
    user_d = res_user;
    flt_d  = res_fault;
    lvl_d  = res_fault_lvl;
    if (accept && !req_paging) begin
      res_en = 1'b1;
      phys_d = req_lin;
      rw_d   = 1'b1;
      user_d = 1'b1;
      flt_d  = 1'b0;
      lvl_d  = 1'b0;
    end else if (dir_flt) begin
      res_en = 1'b1;
      phys_d = '0;
      rw_d   = 1'b0;
      user_d = 1'b0;
      flt_d  = 1'b1;
      lvl_d  = 1'b0;
    end else if (tbl_end) begin
      res_en = 1'b1;
      if (rsp_data[BIT_PRESENT]) begin
        phys_d = {rsp_data[ADDR_W-1:OFF_W], lin_q[OFF_W-1:0]};
        rw_d   = pde_rw_q & rsp_data[BIT_RW];
        user_d = pde_user_q & rsp_data[BIT_USER];
        flt_d  = 1'b0;
        lvl_d  = 1'b0;
      end else begin
        phys_d = '0;
        rw_d   = 1'b0;
        user_d = 1'b0;
        flt_d  = 1'b1;
        lvl_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_phys      <= '0;
      res_rw        <= 1'b0;
      res_user      <= 1'b0;
      res_fault     <= 1'b0;
      res_fault_lvl <= 1'b0;
    end else if (res_en) begin
      res_phys      <= phys_d;
      res_rw        <= rw_d;
      res_user      <= user_d;
      res_fault     <= flt_d;
      res_fault_lvl <= lvl_d;
    end
  end

  // R8
  tbl_fault_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_end && !rsp_data[BIT_PRESENT]) |=> (res_fault && res_fault_lvl));
endmodule

// File: rtl/lin2phys_walker.sv
module lin2phys_walker
  import walk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_lin,
  input  logic [ADDR_W-1:0] req_base,
  input  logic              req_paging,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_phys,
  output logic              res_rw,
  output logic              res_user,
  output logic              res_fault,
  output logic              res_fault_lvl
);
  logic tbl_phase, accept, dir_ok, dir_flt, tbl_end;

  walk_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_paging   (req_paging),
    .mem_rd_ready (mem_rd_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .rsp_present  (mem_rsp_data[BIT_PRESENT]),
    .req_ready    (req_ready),
    .mem_rd_valid (mem_rd_valid),
    .res_valid    (res_valid),
    .tbl_phase    (tbl_phase),
    .accept       (accept),
    .dir_ok       (dir_ok),
    .dir_flt      (dir_flt),
    .tbl_end      (tbl_end)
  );

  walk_dp u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .req_paging   (req_paging),
    .req_lin      (req_lin),
    .req_base     (req_base),
    .dir_ok       (dir_ok),
    .dir_flt      (dir_flt),
    .tbl_end      (tbl_end),
    .tbl_phase    (tbl_phase),
    .rsp_data     (mem_rsp_data),
    .mem_rd_addr  (mem_rd_addr),
    .res_phys     (res_phys),
    .res_rw       (res_rw),
    .res_user     (res_user),
    .res_fault    (res_fault),
    .res_fault_lvl(res_fault_lvl)
  );

  // R3
  bypass_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_paging) |=>
      (res_valid && !mem_rd_valid && !res_fault && res_phys == $past(req_lin)));
  // R10
  rd_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> $stable(mem_rd_addr));
endmodule

// File: tb/lin2phys_walker_tb_top.sv
module lin2phys_walker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic [31:0] req_base = '0;
  logic        req_paging = 1'b0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic [31:0] res_phys;
  logic        res_rw, res_user, res_fault, res_fault_lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin2phys_walker dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .req_base(req_base), .req_paging(req_paging),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_phys(res_phys), .res_rw(res_rw),
    .res_user(res_user), .res_fault(res_fault), .res_fault_lvl(res_fault_lvl)
  );

  typedef struct {
    logic [31:0] phys;
    logic        rw, user, flt, lvl;
    int          reads;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] mem [logic [31:0]];
  int          n_chk = 0, n_bad = 0;
  int          reads_seen = 0, reads_mark = 0, results = 0, sent = 0;
  bit          finished = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected result from the requirements (R3..R9)
  task automatic send(input logic [31:0] lin, input logic [31:0] base, input logic pg, input string tag);
    exp_t e;
    logic [31:0] pde, pte;
    e.tag = tag;
    if (!pg) begin
      e.phys = lin; e.rw = 1; e.user = 1; e.flt = 0; e.lvl = 0; e.reads = 0;
    end else begin
      pde = rd({base[31:12], lin[31:22], 2'b00});
      if (!pde[0]) begin
        e.phys = 0; e.rw = 0; e.user = 0; e.flt = 1; e.lvl = 0; e.reads = 1;
      end else begin
        pte = rd({pde[31:12], lin[21:12], 2'b00});
        e.reads = 2;
        if (!pte[0]) begin
          e.phys = 0; e.rw = 0; e.user = 0; e.flt = 1; e.lvl = 1;
        end else begin
          e.phys = {pte[31:12], lin[11:0]};
          e.rw = pde[1] & pte[1]; e.user = pde[2] & pte[2]; e.flt = 0; e.lvl = 0;
        end
      end
    end
    sb_q.push_back(e);
    sent++;
    req_lin = lin; req_base = base; req_paging = pg; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // memory model with stalls and latency; also watches R10
  initial begin
    bit          pend = 0;
    int          lat = 0, cyc = 0;
    logic [31:0] paddr = '0, hold_addr = '0;
    bit          was_stalled = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (was_stalled) begin
        chk("R10", "rd_valid held", {31'b0, mem_rd_valid}, 32'h1);
        chk("R10", "rd_addr held", mem_rd_addr, hold_addr);
      end
      if (pend) begin
        mem_rd_ready = 1'b0;
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(paddr);
          pend = 0;
        end else lat--;
      end else begin
        mem_rd_ready = (cyc % 3) != 0;
        if (mem_rd_valid && mem_rd_ready) begin
          pend = 1; paddr = mem_rd_addr; lat = cyc % 4; reads_seen++;
        end
      end
      was_stalled = mem_rd_valid && !mem_rd_ready;
      hold_addr   = mem_rd_addr;
    end
  end

  // monitor: pops the scoreboard on each result pulse
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && res_valid) begin
        results++;
        if (sb_q.size() == 0) begin
          chk("R11", "unexpected result", 32'h1, 32'h0);
        end else begin
          e = sb_q.pop_front();
          chk("R6", {e.tag, " phys"}, res_phys, e.phys);
          chk("R9", {e.tag, " rw"}, {31'b0, res_rw}, {31'b0, e.rw});
          chk("R9", {e.tag, " user"}, {31'b0, res_user}, {31'b0, e.user});
          chk("R7", {e.tag, " fault"}, {31'b0, res_fault}, {31'b0, e.flt});
          chk("R8", {e.tag, " fault level"}, {31'b0, res_fault_lvl}, {31'b0, e.lvl});
          chk("R4", {e.tag, " read count (R5)"}, reads_seen - reads_mark, e.reads);
          chk("R2", {e.tag, " busy at result"}, {31'b0, req_ready}, 32'h0);
        end
        reads_mark = reads_seen;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // tables: base A = 0x0010_0000, base B = 0x0030_0000
    mem[{20'h00100, 10'h300, 2'b00}] = 32'h0020_0007;   // present, rw, user
    mem[{20'h00200, 10'h005, 2'b00}] = 32'h1234_5007;
    mem[{20'h00200, 10'h006, 2'b00}] = 32'h0000_0006;   // not present
    mem[{20'h00200, 10'h007, 2'b00}] = 32'h5555_5001;   // present only
    mem[{20'h00100, 10'h001, 2'b00}] = 32'h0020_1005;   // present, user
    mem[{20'h00201, 10'h003, 2'b00}] = 32'h0ABC_D003;   // present, rw
    mem[{20'h00300, 10'h300, 2'b00}] = 32'h0020_2007;
    mem[{20'h00202, 10'h3FF, 2'b00}] = 32'hFFFF_F007;
    // directory index 2 of base A left empty -> level-0 fault

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "req_ready", {31'b0, req_ready}, 32'h1);
    chk("R1", "rd_valid", {31'b0, mem_rd_valid}, 32'h0);
    chk("R1", "res_valid", {31'b0, res_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    send(32'hC000_5ABC, 32'h0010_0000, 1'b1, "R6 walk");
    send(32'hDEAD_BEEF, 32'h0010_0000, 1'b0, "R3 bypass");
    send(32'h0040_3123, 32'h0010_0FFF, 1'b1, "R9 and-attr");
    send(32'h0080_0000, 32'h0010_0000, 1'b1, "R7 dir fault");
    send(32'hC000_6000, 32'h0010_0000, 1'b1, "R8 tbl fault");
    send(32'hC000_7FFF, 32'h0010_0000, 1'b1, "R9 present only");
    send(32'hC03F_FFFF, 32'h0030_0000, 1'b1, "R5 top frame");
    send(32'h0000_0000, 32'h0030_0000, 1'b0, "R3 bypass zero");
    send(32'hC000_5000, 32'h0010_0000, 1'b1, "R4 repeat walk");

    repeat (20) @(negedge clk);
    chk("R11", "results per request", results, sent);
    chk("R11", "queue drained", sb_q.size(), 0);
    finish_run();
  end
endmodule